// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog that sits on a 32-bit register bus with word addresses. Software programs a reload value and switches the timer on through a control register. After that it must keep writing a 16-bit key to a restart register. Each accepted key puts the reload value back into the counter. If software stops doing this and the counter runs out while the timer is enabled, the block issues one reset pulse of programmable length and then stops counting.

The counter advances on a 1 MHz enable input or, when the tick-select bit allows it, on every bus clock. When the memory controller reports that it is itself in reset, an expiry does not produce a reset pulse. The block clears its whole control register instead. The reset output has a programmable polarity and drive type. Both settings change only when a magic byte is written to the top of the pulse configuration register, so a plain width update leaves them alone. Reads return data in the same cycle that the read is presented.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter and the reload value read 0x014FB180, control reads 0x00000010, pulse configuration reads 0x000000FF, the timer is stopped, and the reset output is released (rstOut=0, rstOe=0).
- R2: Word addresses (byte offsets) are: 0 (0x00) counter, read-only, writes ignored; 1 (0x04) reload value, read/write; 2 (0x08) restart, always reads 0; 3 (0x0C) control; 6 (0x18) pulse configuration. Every other word reads 0 and ignores writes.
- R3: A restart write whose low 16 bits equal 0x4755 copies the reload value into the counter, and the countdown runs if control bit 0 is set. A restart write with any other value changes nothing.
- R4: A control write stores the written word with bits 11:8 cleared and bit 4 set. Bit 0 is enable. Bit 4 selects the tick: 1 selects the 1 MHz enable, 0 selects every clock.
- R5: A control write that turns bit 0 from 0 to 1 loads the counter from the reload value and starts the countdown. A write that turns it from 1 to 0 stops the countdown and the counter holds its value. A write that leaves bit 0 unchanged does not touch the counter.
- R6: While the countdown runs, the counter decreases by one per selected tick. A tick that finds the counter at 1 or 0 is an expiry: the counter becomes 0 and the countdown stops.
- R7: On an expiry while memCtlRst is low, a reset pulse starts and control bit 0 stays set. On an expiry while memCtlRst is high, no pulse starts and the control register becomes 0.
- R8: The reset pulse starts at the expiry clock edge and lasts for the number of 1 MHz ticks given by the pulse-width field (bits 19:0). A width of 0 is treated as 1.
- R9: In a pulse-configuration write, a top byte of 0xA5 sets bit 31 (active-high), 0x5A clears bit 31, 0xA8 sets bit 30 (push-pull) and 0x8A clears bit 30. Any other top byte leaves bits 31 and 30 unchanged.
- R10: A pulse-configuration write updates only the width field in bits 19:0. Bits 29:20 always read 0.
- R11: The active level is high when bit 31 is set and low otherwise. In push-pull mode rstOe=1 and rstOut carries the level. In open-drain mode rstOut=0 and rstOe is 1 only while the level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick1us | input | 1 | One-cycle 1 MHz count enable |
| memCtlRst | input | 1 | Memory controller is in reset; suppresses the reset pulse |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| rstOut | output | 1 | Reset output value |
| rstOe | output | 1 | Reset output drive enable |

## Verification
A read returns data in the same cycle it is presented. The bench therefore compares busRdata a moment after the falling edge at which the read was set up. A register write, a key restart or an enable edge takes effect at the next rising edge and is visible on the first read after that edge. A count step and an expiry occur at the rising edge where tick1us, or every clock when bit 4 is cleared, is sampled. The reset pulse changes rstOut and rstOe right after that same expiry edge. A behavioural model in the bench advances at every rising edge from the same inputs. Outputs are checked against the model at every falling edge, so each result is compared in exactly the cycle it is due.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 32;

  // word indices of the mapped registers
  localparam int IDX_COUNT  = 0;
  localparam int IDX_RELOAD = 1;
  localparam int IDX_KICK   = 2;
  localparam int IDX_CTRL   = 3;
  localparam int IDX_PULSE  = 6;

  localparam logic [15:0] KICK_KEY = 16'h4755;

  // top-byte codes of the pulse configuration register
  localparam logic [7:0] CODE_POL_HIGH  = 8'hA5;
  localparam logic [7:0] CODE_POL_LOW   = 8'h5A;
  localparam logic [7:0] CODE_PUSH_PULL = 8'hA8;
  localparam logic [7:0] CODE_OPEN_DRN  = 8'h8A;

  localparam logic [DATA_W-1:0] CTRL_RSVD_MASK = 32'h0000_0F00;
  localparam logic [DATA_W-1:0] CTRL_TICK_BIT  = 32'h0000_0010;

  // strobes from the control side to the counting datapath
  typedef struct packed {
    logic loadCnt;   // copy reload value into the counter
    logic runSet;    // countdown runs after the load
    logic runClr;    // stop the countdown
    logic tickBus;   // count on every clock instead of tick1us
  } dpCmd_t;
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int AW = 4,
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter bit FIXED_TICK = 1'b1,
  parameter logic [CNT_W-1:0] RESET_COUNT = 32'h014F_B180,
  parameter logic [PW_W-1:0] RESET_WIDTH = 20'h000FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [AW-1:0]     busWordAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              expireEvt,
  input  logic              memCtlRst,
  output dpCmd_t            dpCmd,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [PW_W-1:0]   pulseWidth,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              activeHigh,
  output logic              pushPull
);
  localparam logic [DATA_W-1:0] FORCE_MASK = FIXED_TICK ? CTRL_TICK_BIT : '0;
  localparam int GAP_W = DATA_W - 2 - PW_W;

  logic wrEn, wrReload, wrKick, wrCtrl, wrPulse;
  logic kickOk, enRise, enFall;
  logic [DATA_W-1:0] ctrlWrVal;
  logic [7:0] topByte;

  assign wrEn     = busSel && busWr;
  assign wrReload = wrEn && (int'(busWordAddr) == IDX_RELOAD);
  assign wrKick   = wrEn && (int'(busWordAddr) == IDX_KICK);
  assign wrCtrl   = wrEn && (int'(busWordAddr) == IDX_CTRL);
  assign wrPulse  = wrEn && (int'(busWordAddr) == IDX_PULSE);
  assign topByte  = busWdata[DATA_W-1 -: 8];

  assign ctrlWrVal = (busWdata & ~CTRL_RSVD_MASK) | FORCE_MASK;
  assign kickOk    = wrKick && (busWdata[15:0] == KICK_KEY);
  assign enRise    = wrCtrl && busWdata[0] && !ctrlReg[0];
  assign enFall    = wrCtrl && !busWdata[0] && ctrlReg[0];

  always_comb begin
    dpCmd.loadCnt = enRise || kickOk;
    dpCmd.runSet  = enRise || (kickOk && ctrlReg[0]);
    dpCmd.runClr  = enFall;
    dpCmd.tickBus = !ctrlReg[4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal  <= RESET_COUNT;
      ctrlReg    <= FORCE_MASK;
      pulseWidth <= RESET_WIDTH;
      activeHigh <= 1'b0;
      pushPull   <= 1'b0;
    end else begin
      if (wrReload) reloadVal <= busWdata[CNT_W-1:0];
      if (expireEvt && memCtlRst) ctrlReg <= '0;
      else if (wrCtrl) ctrlReg <= ctrlWrVal;
      if (wrPulse) begin
        pulseWidth <= busWdata[PW_W-1:0];
        case (topByte)
          CODE_POL_HIGH:  activeHigh <= 1'b1;
          CODE_POL_LOW:   activeHigh <= 1'b0;
          CODE_PUSH_PULL: pushPull   <= 1'b1;
          CODE_OPEN_DRN:  pushPull   <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      case (int'(busWordAddr))
        IDX_COUNT:  busRdata = DATA_W'(cntVal);
        IDX_RELOAD: busRdata = DATA_W'(reloadVal);
        IDX_CTRL:   busRdata = ctrlReg;
        IDX_PULSE:  busRdata = {activeHigh, pushPull, {GAP_W{1'b0}}, pulseWidth};
        default:    busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kwdt_dp.sv
module kwdt_dp
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter logic [CNT_W-1:0] RESET_COUNT = 32'h014F_B180
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           dpCmd,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [PW_W-1:0]  pulseWidth,
  input  logic             tick1us,
  input  logic             memCtlRst,
  output logic [CNT_W-1:0] cntVal,
  output logic             running,
  output logic             expireEvt,
  output logic             pulseAct
);
  logic tickEn, atEnd;
  logic [PW_W-1:0] pulseCnt;

  assign tickEn    = dpCmd.tickBus || tick1us;
  assign atEnd     = cntVal <= CNT_W'(1);
  assign expireEvt = running && tickEn && atEnd && !dpCmd.loadCnt && !dpCmd.runClr;
  assign pulseAct  = pulseCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= RESET_COUNT;
      running <= 1'b0;
    end else if (dpCmd.loadCnt) begin
      cntVal  <= reloadVal;
      running <= dpCmd.runSet;
    end else if (dpCmd.runClr) begin
      running <= 1'b0;
    end else if (running && tickEn) begin
      if (atEnd) begin
        cntVal  <= '0;
        running <= 1'b0;
      end else begin
        cntVal <= cntVal - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (expireEvt && !memCtlRst) begin
      pulseCnt <= (pulseWidth == '0) ? PW_W'(1) : pulseWidth;
    end else if (pulseAct && tick1us) begin
      pulseCnt <= pulseCnt - PW_W'(1);
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int AW = 4,
  parameter int CNT_W = 32,
  parameter int PW_W = 20,
  parameter bit FIXED_TICK = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick1us,
  input  logic        memCtlRst,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [AW-1:0] busWordAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        rstOut,
  output logic        rstOe
);
  localparam logic [CNT_W-1:0] RESET_COUNT = CNT_W'(32'h014F_B180);
  localparam logic [PW_W-1:0]  RESET_WIDTH = PW_W'(8'hFF);

  dpCmd_t dpCmd;
  logic [CNT_W-1:0] cntVal, reloadVal;
  logic [PW_W-1:0] pulseWidth;
  logic [DATA_W-1:0] ctrlReg;
  logic activeHigh, pushPull, running, expireEvt, pulseAct, level;

  kwdt_ctrl #(
    .AW(AW), .CNT_W(CNT_W), .PW_W(PW_W), .FIXED_TICK(FIXED_TICK),
    .RESET_COUNT(RESET_COUNT), .RESET_WIDTH(RESET_WIDTH)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .expireEvt(expireEvt), .memCtlRst(memCtlRst),
    .dpCmd(dpCmd), .reloadVal(reloadVal), .pulseWidth(pulseWidth),
    .ctrlReg(ctrlReg), .activeHigh(activeHigh), .pushPull(pushPull)
  );

  kwdt_dp #(
    .CNT_W(CNT_W), .PW_W(PW_W), .RESET_COUNT(RESET_COUNT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .reloadVal(reloadVal),
    .pulseWidth(pulseWidth), .tick1us(tick1us), .memCtlRst(memCtlRst),
    .cntVal(cntVal), .running(running), .expireEvt(expireEvt),
    .pulseAct(pulseAct)
  );

  // pin stage: active level, then push-pull or open-drain drive
  assign level  = activeHigh ? pulseAct : !pulseAct;
  assign rstOut = pushPull ? level : 1'b0;
  assign rstOe  = pushPull ? 1'b1 : !level;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             memCtlRst,
  input logic             running,
  input logic             pulseAct,
  input logic             loadCnt,
  input logic [CNT_W-1:0] cntVal,
  input logic [3:0]       ctrlRsvd,
  input logic             pushPull,
  input logic             rstOut,
  input logic             rstOe
);
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRsvd == 4'h0); // R4

  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(loadCnt)) |-> (cntVal <= $past(cntVal))); // R6

  AST_NO_PULSE_IN_MEMRST: assert property (@(posedge clk) disable iff (!rstN)
    $past(memCtlRst) |-> !$rose(pulseAct)); // R7

  AST_PULSE_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseAct) |-> $past(running)); // R8

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    pushPull |-> rstOe); // R11

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !pushPull |-> !rstOut); // R11
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .memCtlRst(memCtlRst), .running(running),
  .pulseAct(pulseAct), .loadCnt(dpCmd.loadCnt), .cntVal(cntVal),
  .ctrlRsvd(ctrlReg[11:8]), .pushPull(pushPull), .rstOut(rstOut), .rstOe(rstOe)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1us = 1'b0;
  logic memCtlRst = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [3:0] busWordAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rstOut, rstOe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = !clk;

  kwdt_top dut_i (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .memCtlRst(memCtlRst),
    .busSel(busSel), .busWr(busWr), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rstOut(rstOut), .rstOe(rstOe)
  );

  // 1 MHz enable stand-in: one cycle in four
  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    tick1us <= (tickDiv == 3);
  end

  // behavioural reference model
  logic [31:0] mCnt, mReload, mCtrl;
  logic [19:0] mWidth;
  logic mHi, mPp, mRun;
  int mPulse;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 32'h014FB180; mReload = 32'h014FB180; mCtrl = 32'h10;
      mWidth = 20'hFF; mHi = 0; mPp = 0; mRun = 0; mPulse = 0;
    end else begin
      bit wr, kick, rise, fall, tickE, expd;
      wr    = busSel && busWr;
      tickE = !mCtrl[4] || tick1us;
      kick  = wr && busWordAddr == 2 && busWdata[15:0] == 16'h4755;
      rise  = wr && busWordAddr == 3 && busWdata[0] && !mCtrl[0];
      fall  = wr && busWordAddr == 3 && !busWdata[0] && mCtrl[0];
      expd  = 0;
      if (rise || kick) begin
        mCnt = mReload;
        mRun = rise || mCtrl[0];
      end else if (fall) begin
        mRun = 0;
      end else if (mRun && tickE) begin
        if (mCnt <= 1) begin mCnt = 0; mRun = 0; expd = 1; end
        else mCnt = mCnt - 1;
      end
      if (expd && !memCtlRst) mPulse = (mWidth == 0) ? 1 : int'(mWidth);
      else if (mPulse > 0 && tick1us) mPulse = mPulse - 1;
      if (wr && busWordAddr == 1) mReload = busWdata;
      if (wr && busWordAddr == 3) mCtrl = (busWdata & ~32'hF00) | 32'h10;
      if (expd && memCtlRst) mCtrl = 0;
      if (wr && busWordAddr == 6) begin
        mWidth = busWdata[19:0];
        if (busWdata[31:24] == 8'hA5) mHi = 1;
        if (busWdata[31:24] == 8'h5A) mHi = 0;
        if (busWdata[31:24] == 8'hA8) mPp = 1;
        if (busWdata[31:24] == 8'h8A) mPp = 0;
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      4'd0: return mCnt;
      4'd1: return mReload;
      4'd3: return mCtrl;
      4'd6: return {mHi, mPp, 10'b0, mWidth};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // output pins compared against the model on every falling edge (R8, R11)
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      bit act, lvl;
      act = mPulse > 0;
      lvl = mHi ? act : !act;
      chk("R8/R11 rstOut", {31'b0, rstOut}, {31'b0, mPp ? lvl : 1'b0});
      chk("R8/R11 rstOe", {31'b0, rstOe}, {31'b0, mPp ? 1'b1 : !lvl});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busWordAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 0; busWr = 0;
  endtask

  task automatic rd(logic [3:0] a, string req);
    @(negedge clk);
    busSel = 1; busWr = 0; busWordAddr = a;
    #1 chk(req, busRdata, modelRead(a));
    @(posedge clk);
    #1 busSel = 0;
  endtask

  task automatic rdExp(logic [3:0] a, string req, logic [31:0] exp);
    @(negedge clk);
    busSel = 1; busWr = 0; busWordAddr = a;
    #1 chk(req, busRdata, exp);
    chk(req, busRdata, modelRead(a));
    @(posedge clk);
    #1 busSel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    rdExp(0, "R1 counter", 32'h014FB180);
    rdExp(1, "R1 reload", 32'h014FB180);
    rdExp(3, "R1 control", 32'h00000010);
    rdExp(6, "R1 pulse cfg", 32'h000000FF);
    chk("R1 rstOut", {31'b0, rstOut}, 32'h0);
    chk("R1 rstOe", {31'b0, rstOe}, 32'h0);
    // R2 map: read-only counter, restart reads 0, unmapped words
    wr(0, 32'h0000_1234);
    rdExp(0, "R2 counter write ignored", 32'h014FB180);
    rdExp(2, "R2 restart reads zero", 32'h0);
    wr(5, 32'hFFFF_FFFF);
    rdExp(5, "R2 unmapped reads zero", 32'h0);
    rdExp(15, "R2 unmapped reads zero", 32'h0);
    // R4 control sanitising
    wr(3, 32'hFFFF_FFFE);
    rdExp(3, "R4 ctrl bits 11:8 cleared", 32'hFFFF_F0FE);
    wr(3, 32'h0000_0F00);
    rdExp(3, "R4 ctrl bit4 forced", 32'h0000_0010);
    // R10 / R9 pulse configuration
    wr(6, 32'h1234_5678);
    rdExp(6, "R10 width only", 32'h0004_5678);
    wr(6, 32'hA500_0003);
    rdExp(6, "R9 active-high set", 32'h8000_0003);
    wr(6, 32'hA800_0003);
    rdExp(6, "R9 push-pull set", 32'hC000_0003);
    wr(6, 32'h5A00_0003);
    rdExp(6, "R9 active-high cleared", 32'h4000_0003);
    // R5/R6/R7/R8: enable, count down, expire with pulse
    wr(1, 32'd5);
    wr(3, 32'h0000_0011);
    rdExp(0, "R5 enable rise loads", 32'd5);
    idle(6);
    rd(0, "R6 counting down");
    idle(30);
    rdExp(0, "R6 expired at zero", 32'h0);
    rdExp(3, "R7 enable kept after expiry", 32'h0000_0011);
    idle(20);
    // R3 bad key ignored, good key reloads and runs
    wr(2, 32'h0000_1234);
    rdExp(0, "R3 bad key ignored", 32'h0);
    wr(2, 32'hABCD_4755);
    rdExp(0, "R3 key reloads", 32'd5);
    // keep alive with repeated keys
    wr(1, 32'd12);
    for (int i = 0; i < 6; i++) begin
      wr(2, 32'h0000_4755);
      idle(12);
      rd(0, "R3 keep alive");
    end
    // R5 unchanged enable does not reload
    wr(3, 32'h0000_0011);
    idle(12);
    rd(0, "R5 unchanged enable");
    // R5 disable holds the counter
    wr(3, 32'h0000_0010);
    rd(0, "R5 disabled hold a");
    idle(20);
    rd(0, "R5 disabled hold b");
    // R3 key while disabled loads but does not run
    wr(2, 32'h0000_4755);
    idle(20);
    rdExp(0, "R3 key while disabled", 32'd12);
    // R7 expiry during memory-controller reset
    memCtlRst = 1;
    wr(1, 32'd3);
    wr(3, 32'h0000_0071);
    idle(24);
    rdExp(3, "R7 control cleared", 32'h0);
    rdExp(0, "R7 counter at zero", 32'h0);
    memCtlRst = 0;
    // R11 open-drain active-high, R8 width zero -> one tick
    wr(6, 32'h8A00_0000);
    wr(6, 32'hA500_0000);
    rdExp(6, "R9 open-drain high", 32'h8000_0000);
    wr(1, 32'd2);
    wr(3, 32'h0000_0001);
    idle(30);
    rdExp(0, "R6 second expiry", 32'h0);
    idle(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule